// File: doc/BRIEF.md
# Global-History Hashed Direction Predictor

This block predicts whether a conditional branch will be taken, for a fetch stage that issues one instruction per cycle. A global outcome history holds the directions of the most recently resolved conditional branches, whatever their address. The history is combined by exclusive-OR with the low word-address bits of the branch PC. The result selects one entry of a pattern table. Each entry is a 2-bit saturating counter.

The predict side is purely combinational. Fetch presents a PC and gets a direction in the same cycle. It also gets the history value that was used, which it carries down the pipeline with the branch. When the branch resolves, the resolve port returns the PC, the actual direction and that carried history. The update therefore trains the exact entry that produced the prediction, and it shifts the real outcome into the global history.

Each counter is a four-state machine: STRONG_NT (00), WEAK_NT (01), WEAK_T (10) and STRONG_T (11). On a taken resolve it moves one state towards STRONG_T; the transitions are STRONG_NT→WEAK_NT, WEAK_NT→WEAK_T, WEAK_T→STRONG_T and STRONG_T→STRONG_T. On a not-taken resolve it moves one state towards STRONG_NT; the transitions are STRONG_T→WEAK_T, WEAK_T→WEAK_NT, WEAK_NT→STRONG_NT and STRONG_NT→STRONG_NT. With no resolve, every state holds. Entries carry no tag, so branches whose index collides share one counter.

Top module: `gshare_predictor`

## Requirements
- R1: After reset, every counter is in WEAK_NT (01), so every PC predicts not-taken, and `pred_hist` reads zero.
- R2: `pred_taken` is the upper bit of the counter at index `pred_pc[IDX_W+1:2] XOR hist`, where hist is the newest IDX_W bits of `pred_hist`. It is available in the same cycle as `pred_pc`.
- R3: A resolve with `res_taken`=1 moves the selected counter up by one, and STRONG_T (11) stays at 11.
- R4: A resolve with `res_taken`=0 moves the selected counter down by one, and STRONG_NT (00) stays at 00.
- R5: Each resolve shifts `res_taken` into bit 0 of the history and drops the oldest bit. The new value appears on `pred_hist` in the next cycle.
- R6: The trained entry is selected by `res_pc` and `res_hist`, not by the current global history.
- R7: A prediction in the same cycle as a resolve reads the table as it was before that update.
- R8: Two PCs that give the same index share one counter, and no tag check is made.
- R9: With the default history, a single branch that repeats taken, taken, taken, not-taken is predicted with no misses once it has been trained.
- R10: While `res_valid` is 0, neither the table nor the history changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pred_pc | input | PC_W | Address of the branch being fetched |
| pred_taken | output | 1 | Predicted direction, 1 = taken |
| pred_hist | output | HIST_W | Global history used for this prediction |
| res_valid | input | 1 | A branch resolves this cycle |
| res_pc | input | PC_W | Address of the resolving branch |
| res_taken | input | 1 | Actual direction of the resolving branch |
| res_hist | input | HIST_W | History returned from prediction time |

## Verification
The bench pushes a counter past both ends of its range and then reverses it once. A counter that wraps instead of saturating would then give the wrong direction. It trains an entry through a `res_hist` that differs from the live history, and then predicts the entry at that index. A design that indexed the update by the live history would train the wrong entry. It also predicts and resolves the same entry in one cycle, to catch a table that is bypassed with its own update. It checks that an aliased PC inherits training, that idle cycles change nothing, and that a repeating loop branch converges to no misses.

// File: rtl/gsp_pkg.sv
package gsp_pkg;

    // Two-bit direction counter states; the upper bit is the prediction.
    typedef enum logic [1:0] {
        STRONG_NT = 2'b00,
        WEAK_NT   = 2'b01,
        WEAK_T    = 2'b10,
        STRONG_T  = 2'b11
    } ctr_state_t;

    localparam ctr_state_t CTR_RESET = WEAK_NT;

endpackage

// File: rtl/gsp_sat_ctr.sv
module gsp_sat_ctr
    import gsp_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       upd_en,
    input  logic       upd_taken,
    output logic [1:0] state_o,
    output logic       taken_o
);

    ctr_state_t state_q;
    ctr_state_t state_d;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= CTR_RESET;
        end else begin
            state_q <= state_d;
        end
    end

    // transitions
    always_comb begin
        state_d = state_q;
        if (upd_en) begin
            unique case (state_q)
                STRONG_NT: state_d = upd_taken ? WEAK_NT  : STRONG_NT;
                WEAK_NT:   state_d = upd_taken ? WEAK_T   : STRONG_NT;
                WEAK_T:    state_d = upd_taken ? STRONG_T : WEAK_NT;
                STRONG_T:  state_d = upd_taken ? STRONG_T : WEAK_T;
                default:   state_d = CTR_RESET;
            endcase
        end
    end

    // outputs
    always_comb begin
        state_o = state_q;
        unique case (state_q)
            STRONG_NT, WEAK_NT: taken_o = 1'b0;
            WEAK_T, STRONG_T:   taken_o = 1'b1;
            default:            taken_o = 1'b0;
        endcase
    end

endmodule

// File: rtl/gsp_ghr.sv
module gsp_ghr #(
    parameter int HIST_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              shift_en,
    input  logic              bit_in,
    output logic [HIST_W-1:0] hist_o
);

    logic [HIST_W-1:0] hist_q;
    logic [HIST_W-1:0] hist_d;

    generate
        if (HIST_W == 1) begin : g_single
            always_comb hist_d = shift_en ? bit_in : hist_q;
        end else begin : g_multi
            always_comb hist_d = shift_en ? {hist_q[HIST_W-2:0], bit_in} : hist_q;
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hist_q <= '0;
        end else begin
            hist_q <= hist_d;
        end
    end

    assign hist_o = hist_q;

endmodule

// File: rtl/gsp_hash.sv
module gsp_hash #(
    parameter int PC_W   = 32,
    parameter int PC_LSB = 2,
    parameter int IDX_W  = 8,
    parameter int HIST_W = 8
) (
    input  logic [PC_W-1:0]   pc,
    input  logic [HIST_W-1:0] hist,
    output logic [IDX_W-1:0]  idx
);

    logic [IDX_W-1:0] pc_bits;
    logic [IDX_W-1:0] hist_bits;

    assign pc_bits = pc[PC_LSB +: IDX_W];

    // newest history bits sit at the bottom; pad or trim to the index width
    generate
        if (HIST_W >= IDX_W) begin : g_trim
            assign hist_bits = hist[IDX_W-1:0];
        end else begin : g_pad
            assign hist_bits = {{(IDX_W-HIST_W){1'b0}}, hist};
        end
    endgenerate

    assign idx = pc_bits ^ hist_bits;

endmodule

// File: rtl/gsp_pht.sv
module gsp_pht #(
    parameter int IDX_W = 8
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [IDX_W-1:0]          rd_idx,
    output logic                      rd_taken,
    input  logic                      wr_en,
    input  logic [IDX_W-1:0]          wr_idx,
    input  logic                      wr_taken,
    output logic [2*(1<<IDX_W)-1:0]   ctr_flat
);

    localparam int DEPTH = 1 << IDX_W;

    logic [DEPTH-1:0] dir_vec;
    logic [DEPTH-1:0] sel_vec;

    generate
        for (genvar e = 0; e < DEPTH; e++) begin : g_ent
            assign sel_vec[e] = wr_en && (wr_idx == IDX_W'(e));
            gsp_sat_ctr u_ctr (
                .clk       (clk),
                .rst_n     (rst_n),
                .upd_en    (sel_vec[e]),
                .upd_taken (wr_taken),
                .state_o   (ctr_flat[2*e +: 2]),
                .taken_o   (dir_vec[e])
            );
        end
    endgenerate

    // read returns registered state: an update in this cycle is not visible yet
    assign rd_taken = dir_vec[rd_idx];

endmodule

// File: rtl/gshare_predictor.sv
module gshare_predictor #(
    parameter int PC_W   = 32,
    parameter int PC_LSB = 2,
    parameter int IDX_W  = 8,
    parameter int HIST_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [PC_W-1:0]   pred_pc,
    output logic              pred_taken,
    output logic [HIST_W-1:0] pred_hist,
    input  logic              res_valid,
    input  logic [PC_W-1:0]   res_pc,
    input  logic              res_taken,
    input  logic [HIST_W-1:0] res_hist
);

    localparam int DEPTH = 1 << IDX_W;

    logic [HIST_W-1:0]  ghr;
    logic [IDX_W-1:0]   rd_idx;
    logic [IDX_W-1:0]   wr_idx;
    logic [2*DEPTH-1:0] ctr_flat;

    gsp_ghr #(.HIST_W(HIST_W)) u_ghr (
        .clk      (clk),
        .rst_n    (rst_n),
        .shift_en (res_valid),
        .bit_in   (res_taken),
        .hist_o   (ghr)
    );

    gsp_hash #(.PC_W(PC_W), .PC_LSB(PC_LSB), .IDX_W(IDX_W), .HIST_W(HIST_W)) u_rd_hash (
        .pc   (pred_pc),
        .hist (ghr),
        .idx  (rd_idx)
    );

    gsp_hash #(.PC_W(PC_W), .PC_LSB(PC_LSB), .IDX_W(IDX_W), .HIST_W(HIST_W)) u_wr_hash (
        .pc   (res_pc),
        .hist (res_hist),
        .idx  (wr_idx)
    );

    gsp_pht #(.IDX_W(IDX_W)) u_pht (
        .clk      (clk),
        .rst_n    (rst_n),
        .rd_idx   (rd_idx),
        .rd_taken (pred_taken),
        .wr_en    (res_valid),
        .wr_idx   (wr_idx),
        .wr_taken (res_taken),
        .ctr_flat (ctr_flat)
    );

    assign pred_hist = ghr;

endmodule

// File: rtl/gsp_chk.sv
module gsp_chk #(
    parameter int PC_W   = 32,
    parameter int PC_LSB = 2,
    parameter int IDX_W  = 8,
    parameter int HIST_W = 8
) (
    input logic                        clk,
    input logic                        rst_n,
    input logic [PC_W-1:0]             pred_pc,
    input logic                        pred_taken,
    input logic [HIST_W-1:0]           pred_hist,
    input logic                        res_valid,
    input logic [PC_W-1:0]             res_pc,
    input logic                        res_taken,
    input logic [HIST_W-1:0]           res_hist,
    input logic [2*(1<<IDX_W)-1:0]     ctr_flat
);

    logic [IDX_W-1:0] p_idx;
    logic [IDX_W-1:0] w_idx;
    logic [1:0]       w_cur;

    assign p_idx = pred_pc[PC_LSB +: IDX_W] ^ IDX_W'(pred_hist);
    assign w_idx = res_pc[PC_LSB +: IDX_W] ^ IDX_W'(res_hist);
    assign w_cur = ctr_flat[2*int'(w_idx) +: 2];

    AST_RESET_HIST: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> pred_hist == '0); // R1
    AST_PRED_MSB: assert property (@(posedge clk) disable iff (!rst_n)
        pred_taken == ctr_flat[2*int'(p_idx)+1]); // R2
    AST_CTR_INC: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && res_taken && w_cur != 2'b11) |=> ctr_flat[2*int'($past(w_idx)) +: 2] == $past(w_cur) + 2'd1); // R3
    AST_CTR_SAT_HI: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && res_taken && w_cur == 2'b11) |=> ctr_flat[2*int'($past(w_idx)) +: 2] == 2'b11); // R3
    AST_CTR_DEC: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && !res_taken && w_cur != 2'b00) |=> ctr_flat[2*int'($past(w_idx)) +: 2] == $past(w_cur) - 2'd1); // R4
    AST_CTR_SAT_LO: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && !res_taken && w_cur == 2'b00) |=> ctr_flat[2*int'($past(w_idx)) +: 2] == 2'b00); // R4
    AST_HIST_SHIFT: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |=> pred_hist == HIST_W'({$past(pred_hist), $past(res_taken)})); // R5
    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !res_valid |=> $stable(pred_hist) && $stable(ctr_flat)); // R10

endmodule

bind gshare_predictor gsp_chk #(
    .PC_W(PC_W), .PC_LSB(PC_LSB), .IDX_W(IDX_W), .HIST_W(HIST_W)
) u_chk (
    .clk(clk), .rst_n(rst_n), .pred_pc(pred_pc), .pred_taken(pred_taken),
    .pred_hist(pred_hist), .res_valid(res_valid), .res_pc(res_pc),
    .res_taken(res_taken), .res_hist(res_hist), .ctr_flat(ctr_flat)
);

// File: tb/sim_gshare_predictor.sv
module sim_gshare_predictor;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] pred_pc = '0;
    logic        pred_taken;
    logic [7:0]  pred_hist;
    logic        res_valid = 1'b0;
    logic [31:0] res_pc = '0;
    logic        res_taken = 1'b0;
    logic [7:0]  res_hist = '0;

    int checks = 0;
    int fails  = 0;

    logic [1:0] m_ctr [256];
    logic [7:0] m_hist;

    always #10 clk = ~clk;

    gshare_predictor u0 (
        .clk(clk), .rst_n(rst_n), .pred_pc(pred_pc), .pred_taken(pred_taken),
        .pred_hist(pred_hist), .res_valid(res_valid), .res_pc(res_pc),
        .res_taken(res_taken), .res_hist(res_hist)
    );

    // {taken, pc}
    localparam logic [32:0] VEC [16] = '{
        {1'b1, 32'h0000_0100}, {1'b1, 32'h0000_0100}, {1'b0, 32'h0000_0204},
        {1'b1, 32'h0000_0100}, {1'b1, 32'h0000_0310}, {1'b0, 32'h0000_0310},
        {1'b1, 32'h0000_0100}, {1'b1, 32'h0000_0100}, {1'b0, 32'h0000_0204},
        {1'b0, 32'h0000_0204}, {1'b1, 32'h0000_0abc}, {1'b1, 32'h0000_0abc},
        {1'b0, 32'h0000_0100}, {1'b1, 32'h0000_0310}, {1'b0, 32'h0000_0abc},
        {1'b1, 32'h0000_0204}
    };

    function automatic logic [7:0] midx(input logic [31:0] pc, input logic [7:0] h);
        return pc[9:2] ^ h;
    endfunction

    function automatic logic [31:0] pc_for(input logic [7:0] idx, input logic [7:0] h);
        return {22'd0, idx ^ h, 2'b00};
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // finish the current cycle: clock edge, update the model, go to the next falling edge
    task automatic cyc();
        @(posedge clk);
        if (rst_n && res_valid) begin
            logic [7:0] i;
            i = midx(res_pc, res_hist);
            if (res_taken) m_ctr[i] = (m_ctr[i] == 2'b11) ? 2'b11 : m_ctr[i] + 2'd1;
            else           m_ctr[i] = (m_ctr[i] == 2'b00) ? 2'b00 : m_ctr[i] - 2'd1;
            m_hist = {m_hist[6:0], res_taken};
        end
        @(negedge clk);
    endtask

    task automatic resolve_fixed(input logic [31:0] pc, input logic [7:0] h, input logic t);
        res_valid = 1'b1; res_pc = pc; res_hist = h; res_taken = t;
        cyc();
        res_valid = 1'b0;
    endtask

    initial begin
        #(20 * 200000);
        fails++;
        $display("FAIL watchdog actual=running expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        foreach (m_ctr[i]) m_ctr[i] = 2'b01;
        m_hist = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #5;

        // R1: reset state
        chk("R1 hist", 32'(pred_hist), 32'h0);
        for (int k = 0; k < 4; k++) begin
            pred_pc = 32'h40 * k + 32'h1000;
            #1;
            chk("R1 pred", 32'(pred_taken), 32'h0);
        end
        @(negedge clk);

        // R2 R5 R7: vector walk, predict and resolve the same branch each cycle
        foreach (VEC[v]) begin
            pred_pc = VEC[v][31:0];
            #1;
            res_valid = 1'b1; res_pc = pred_pc; res_taken = VEC[v][32]; res_hist = pred_hist;
            #4;
            chk("R5 hist", 32'(pred_hist), 32'(m_hist));
            chk("R2 R7 pred", 32'(pred_taken), 32'(m_ctr[midx(pred_pc, m_hist)][1]));
            cyc();
        end
        res_valid = 1'b0;

        // R3: saturate high, then one step down stays taken
        for (int k = 0; k < 5; k++) resolve_fixed(32'h0000_0040, 8'h5a, 1'b1);
        resolve_fixed(32'h0000_0040, 8'h5a, 1'b0);
        pred_pc = pc_for(midx(32'h0000_0040, 8'h5a), m_hist);
        #5;
        chk("R3 sat high", 32'(pred_taken), 32'h1);
        @(negedge clk);

        // R4: saturate low, then one step up stays not-taken
        for (int k = 0; k < 5; k++) resolve_fixed(32'h0000_0080, 8'h33, 1'b0);
        resolve_fixed(32'h0000_0080, 8'h33, 1'b1);
        pred_pc = pc_for(midx(32'h0000_0080, 8'h33), m_hist);
        #5;
        chk("R4 sat low", 32'(pred_taken), 32'h0);
        @(negedge clk);

        // R6: training uses res_hist, not the live history
        resolve_fixed(32'h0000_0600, 8'hc3, 1'b1);
        resolve_fixed(32'h0000_0600, 8'hc3, 1'b1);
        pred_pc = pc_for(midx(32'h0000_0600, 8'hc3), m_hist);
        #5;
        chk("R6 trained idx", 32'(pred_taken), 32'h1);
        pred_pc = pc_for(midx(32'h0000_0600, m_hist), m_hist);
        #1;
        chk("R6 live idx", 32'(pred_taken), 32'(m_ctr[midx(32'h0000_0600, m_hist)][1]));
        @(negedge clk);

        // R8: aliasing, bits above the index and below bit 2 do not matter
        pred_pc = pc_for(midx(32'h0000_0600, 8'hc3), m_hist) | 32'h0001_0403;
        #5;
        chk("R8 alias", 32'(pred_taken), 32'h1);
        @(negedge clk);

        // R10: idle cycles with changing resolve fields
        begin
            logic [7:0] h0;
            h0 = pred_hist;
            for (int k = 0; k < 4; k++) begin
                res_valid = 1'b0; res_pc = 32'h0000_0600; res_hist = 8'hc3; res_taken = k[0];
                @(negedge clk);
            end
            #5;
            chk("R10 hist", 32'(pred_hist), 32'(h0));
            chk("R10 table", 32'(pred_taken), 32'h1);
            @(negedge clk);
        end

        // R9: repeating T T T N loop branch converges
        begin
            int miss;
            miss = 0;
            for (int it = 0; it < 40; it++) begin
                for (int k = 0; k < 4; k++) begin
                    pred_pc = 32'h0000_2000;
                    #1;
                    res_valid = 1'b1; res_pc = pred_pc; res_taken = (k != 3); res_hist = pred_hist;
                    #4;
                    if (it >= 30 && pred_taken !== (k != 3)) miss++;
                    cyc();
                end
            end
            res_valid = 1'b0;
            chk("R9 loop misses", 32'(miss), 32'h0);
        end

        // R1: reset again restores weakly not-taken and clears history
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        foreach (m_ctr[i]) m_ctr[i] = 2'b01;
        m_hist = '0;
        pred_pc = 32'h0000_2000;
        #5;
        chk("R1 re-reset hist", 32'(pred_hist), 32'h0);
        chk("R1 re-reset pred", 32'(pred_taken), 32'h0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule